// File: doc/BRIEF.md
# One-Wire Master Interrupt Flag and Enable Unit

This block keeps the interrupt flag register and the interrupt enable register of a one-wire bus master that sits on a byte-wide register bus. The bit-timing engine and the shift registers are outside it. They report to it through event pulses and one level input. The block latches those events as flags, decodes reads and writes of its two registers, and applies the clear-on-read side effects. It combines flags with enables to drive a single interrupt line whose active level software selects.

The interrupt line asserts when an armed request rises. An armed request is a flag together with its enable. A read of the flag register releases the line, even if a level flag is still present. One enable bit sets the output polarity. That bit never counts as an armed source, so with no source enabled the line rests at its idle level.

Top module: `owm_irq_unit`

## Requirements
- R1: After reset both registers read 0x00 and the interrupt line sits at its idle level of 1 (polarity bit clear means active-low).
- R2: The enable register keeps bits 0, 2, 3, 4, 5 and 6 as written and reads 0 in bits 1 and 7. Bit 0 arms presence-done, bit 2 arms receive-buffer-full, bit 3 arms transmit-shift-empty, bit 4 is the polarity bit, bit 5 arms receive-shift-full, and bit 6 is a stored direct-drive bit.
- R3: A presence-done pulse sets flag bit 0. In the same cycle, flag bit 1 captures the no-slave input: 1 means no slave answered, 0 means a slave is present. Bit 1 holds until the next presence-done pulse.
- R4: A flag register read returns the value the flags had before the read, in rdata in the following cycle. It then clears bit 0 and bit 5 (receive-shift-full). Bits 1, 2 and 3 are left as they were.
- R5: A receive-buffer-full pulse sets flag bit 2. Only a read at the data register offset clears that bit.
- R6: Flag bit 3 follows the transmit-shift-empty input with one cycle of delay, and no read clears it.
- R7: When a flag-setting event and a clearing read occur in the same cycle, the flag stays set.
- R8: The line goes active in the cycle after any of the pairs (flag 0, enable 0), (2,2), (3,3) or (5,5) goes from not both set to both set. This includes the case where an enable write arms a flag that is already set.
- R9: A flag register read returns the line to idle in the following cycle, unless a new armed request rises in that same cycle.
- R10: With enable bits 0, 2, 3 and 5 all clear, the line is inactive, at level NOT(enable bit 4).
- R11: With enable bit 4 set the line is active-high; with it clear the line is active-low.
- R12: Writes to any offset other than 0x03 change no state. Reads at offsets other than 0x02 and 0x03 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| ev_presence_done | input | 1 | Pulse: reset/presence sequence finished |
| ev_no_slave | input | 1 | Presence result, sampled with ev_presence_done |
| ev_rx_buf_full | input | 1 | Pulse: receive buffer loaded |
| ev_rx_shift_full | input | 1 | Pulse: receive shift register full |
| st_tx_shift_empty | input | 1 | Level: transmit shift register empty |
| irq_line | output | 1 | Interrupt output, polarity from enable bit 4 |

## Verification
The assertions assume that a read and a write never happen in the same cycle. They also assume that every event input is sampled on the clock edge only. The bench drives all inputs at the falling edge and never raises bus_rd and bus_wr together. Same-cycle collisions are produced only between an event pulse and a read, which is the case that R7 and R9 cover. The sweep resets the unit for each of the sixteen combinations of set sources. It then writes every enable value, clearing the enables to zero before each one, so that every armed request starts from a known low state.

// File: rtl/owm_irq_pkg.sv
package owm_irq_pkg;
  localparam int REG_W = 8;
  // flag register bit positions
  localparam int FB_PD   = 0;
  localparam int FB_PDR  = 1;
  localparam int FB_RBF  = 2;
  localparam int FB_TSRE = 3;
  localparam int FB_RSRF = 5;
  // enable register bit positions
  localparam int EB_POL  = 4;
  localparam int EB_DRV  = 6;
  localparam logic [REG_W-1:0] SRC_MASK = 8'h2D;
  localparam logic [REG_W-1:0] EN_MASK  = 8'h7D;
endpackage

// File: rtl/owm_flag_bank.sv
module owm_flag_bank
  import owm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_done,
  input  logic             pd_noslave,
  input  logic             rx_buf_full,
  input  logic             rx_sh_full,
  input  logic             tx_sh_empty,
  input  logic             clr_flag_rd,
  input  logic             clr_data_rd,
  output logic [REG_W-1:0] flags_q,
  output logic [REG_W-1:0] flags_d
);
  always_comb begin
    flags_d          = '0;
    flags_d[FB_PD]   = pd_done | (flags_q[FB_PD] & ~clr_flag_rd);
    flags_d[FB_PDR]  = pd_done ? pd_noslave : flags_q[FB_PDR];
    flags_d[FB_RBF]  = rx_buf_full | (flags_q[FB_RBF] & ~clr_data_rd);
    flags_d[FB_TSRE] = tx_sh_empty;
    flags_d[FB_RSRF] = rx_sh_full | (flags_q[FB_RSRF] & ~clr_flag_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_pd_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pd_done |=> flags_q[FB_PD] && flags_q[FB_PDR] == $past(pd_noslave));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag_rd && !pd_done && !rx_sh_full |=> !flags_q[FB_PD] && !flags_q[FB_RSRF]);
  assert_rbf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_data_rd && !rx_buf_full |=> !flags_q[FB_RBF]);
  assert_rbf_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FB_RBF] && !clr_data_rd |=> flags_q[FB_RBF]);
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sh_full && clr_flag_rd |=> flags_q[FB_RSRF]);
  assert_tsre_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sh_empty) |=> flags_q[FB_TSRE]);
endmodule

// File: rtl/owm_enable_reg.sv
module owm_enable_reg
  import owm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] en_d
);
  assign en_d = wr_stb ? (wdata & EN_MASK) : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assert_en_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(en_q));
  assert_en_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> en_q[EB_POL] == $past(wdata[EB_POL]));
endmodule

// File: rtl/owm_irq_drive.sv
module owm_irq_drive
  import owm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] flags_q,
  input  logic [REG_W-1:0] flags_d,
  input  logic [REG_W-1:0] en_q,
  input  logic [REG_W-1:0] en_d,
  input  logic             flag_rd,
  output logic             irq_line
);
  logic [REG_W-1:0] req_q, req_d, rise;
  logic             pend_q, pend_d, armed_any;

  assign req_q     = flags_q & en_q & SRC_MASK;
  assign req_d     = flags_d & en_d & SRC_MASK;
  assign rise      = req_d & ~req_q;
  assign pend_d    = (pend_q & ~flag_rd) | (|rise);
  assign armed_any = |req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // active level chosen by polarity bit
  assign irq_line = en_q[EB_POL] ? (pend_q & armed_any) : ~(pend_q & armed_any);

  assert_idle_noen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & SRC_MASK) == '0 |-> irq_line == !en_q[EB_POL]);
  assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    |rise |=> irq_line == en_q[EB_POL]);
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && !(|rise) |=> irq_line == !en_q[EB_POL]);
endmodule

// File: rtl/owm_irq_unit.sv
module owm_irq_unit
  import owm_irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_OFS = 1,
  parameter int FLAG_OFS = 2,
  parameter int ENAB_OFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ev_presence_done,
  input  logic              ev_no_slave,
  input  logic              ev_rx_buf_full,
  input  logic              ev_rx_shift_full,
  input  logic              st_tx_shift_empty,
  output logic              irq_line
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(ENAB_OFS);

  logic             flag_rd, data_rd, en_wr;
  logic [REG_W-1:0] flags_q, flags_d, en_q, en_d, rd_mux;

  assign flag_rd = bus_rd & (bus_addr == A_FLAG);
  assign data_rd = bus_rd & (bus_addr == A_DATA);
  assign en_wr   = bus_wr & (bus_addr == A_ENAB);

  owm_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .pd_done(ev_presence_done), .pd_noslave(ev_no_slave),
    .rx_buf_full(ev_rx_buf_full), .rx_sh_full(ev_rx_shift_full),
    .tx_sh_empty(st_tx_shift_empty),
    .clr_flag_rd(flag_rd), .clr_data_rd(data_rd),
    .flags_q(flags_q), .flags_d(flags_d)
  );

  owm_enable_reg u_enab (
    .clk(clk), .rst_n(rst_n), .wr_stb(en_wr), .wdata(bus_wdata),
    .en_q(en_q), .en_d(en_d)
  );

  owm_irq_drive u_drive (
    .clk(clk), .rst_n(rst_n), .flags_q(flags_q), .flags_d(flags_d),
    .en_q(en_q), .en_d(en_d), .flag_rd(flag_rd), .irq_line(irq_line)
  );

  always_comb begin
    if (bus_addr == A_FLAG)      rd_mux = flags_q;
    else if (bus_addr == A_ENAB) rd_mux = en_q;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_no_collide_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_rd_other_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr != A_FLAG && bus_addr != A_ENAB |=> bus_rdata == '0);
endmodule

// File: tb/owm_irq_unit_tb_top.sv
module owm_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ev_pd = 1'b0, ev_ns = 1'b0, ev_rbf = 1'b0, ev_rsf = 1'b0, tx_e = 1'b0;
  logic       irq_line;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  owm_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_presence_done(ev_pd), .ev_no_slave(ev_ns), .ev_rx_buf_full(ev_rbf),
    .ev_rx_shift_full(ev_rsf), .st_tx_shift_empty(tx_e), .irq_line(irq_line)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock edge, then drop all strobes and pulses (we stay at negedge)
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; ev_pd = 0; ev_rbf = 0; ev_rsf = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tx_e = 0; ev_ns = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step();
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    bus_addr = a; bus_rd = 1; step();
    check(tag, bus_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] fm, ev;
    logic       act;
    do_reset();
    // R1
    check("R1 line", {7'd0, irq_line}, 8'h01);
    rd(3'd2, 8'h00, "R1 flags");
    rd(3'd3, 8'h00, "R1 enable");

    // sweep: R2 R8 R10 R11
    for (int c = 0; c < 16; c++) begin
      do_reset();
      fm = {2'b0, c[3], 1'b0, c[2], c[1], 1'b0, c[0]};
      ev_pd = c[0]; ev_rbf = c[1]; tx_e = c[2]; ev_rsf = c[3];
      step();
      for (int v = 0; v < 256; v++) begin
        wr(3'd3, 8'h00);
        wr(3'd3, v[7:0]);
        ev  = v[7:0];
        act = |(ev & fm & 8'h2D);
        check(ev[4] ? "R8 R11 line hi-pol" : "R8 R10 line lo-pol",
              {7'd0, irq_line}, {7'd0, ev[4] ? act : ~act});
        rd(3'd3, ev & 8'h7D, "R2 enable readback");
      end
    end

    // R3
    do_reset();
    ev_pd = 1; ev_ns = 1; step();
    rd(3'd2, 8'h03, "R3 no slave");
    rd(3'd2, 8'h02, "R3 R4 PDR kept, PD cleared");
    ev_pd = 1; ev_ns = 0; step();
    rd(3'd2, 8'h01, "R3 slave present");
    rd(3'd2, 8'h00, "R4 PD cleared");

    // R4 R9 with active-high, presence source armed
    wr(3'd3, 8'h11);
    check("R11 idle hi-pol", {7'd0, irq_line}, 8'h00);
    ev_pd = 1; ev_rsf = 1; step();
    check("R8 line asserted", {7'd0, irq_line}, 8'h01);
    rd(3'd2, 8'h21, "R4 pre-clear value");
    check("R9 released", {7'd0, irq_line}, 8'h00);
    rd(3'd2, 8'h00, "R4 PD RSRF cleared");

    // R5
    ev_rbf = 1; step();
    rd(3'd2, 8'h04, "R5 RBF set");
    rd(3'd2, 8'h04, "R5 RBF survives flag read");
    rd(3'd1, 8'h00, "R12 data offset reads zero");
    rd(3'd2, 8'h00, "R5 RBF cleared by data read");

    // R6
    tx_e = 1; step();
    rd(3'd2, 8'h08, "R6 TSRE follows");
    rd(3'd2, 8'h08, "R6 TSRE not cleared");
    tx_e = 0; step();
    rd(3'd2, 8'h00, "R6 TSRE drops");

    // R7
    ev_pd = 1; bus_addr = 3'd2; bus_rd = 1; step();
    check("R7 read returns old", bus_rdata, 8'h00);
    rd(3'd2, 8'h01, "R7 PD kept");
    ev_rbf = 1; bus_addr = 3'd1; bus_rd = 1; step();
    rd(3'd2, 8'h04, "R7 RBF kept");
    rd(3'd1, 8'h00, "R5 data read");

    // R9 with level source still present, active-low
    do_reset();
    wr(3'd3, 8'h08);
    check("R10 idle lo-pol", {7'd0, irq_line}, 8'h01);
    tx_e = 1; step();
    check("R8 TSRE asserts", {7'd0, irq_line}, 8'h00);
    rd(3'd2, 8'h08, "R9 flag value");
    check("R9 released with TSRE held", {7'd0, irq_line}, 8'h01);
    // R8 arming a set flag by enable write
    ev_pd = 1; step();
    check("R8 PD not armed", {7'd0, irq_line}, 8'h01);
    wr(3'd3, 8'h19);
    check("R8 arm by write", {7'd0, irq_line}, 8'h01);
    // R9 new rise same cycle as read keeps line
    wr(3'd3, 8'h18);
    ev_pd = 1; step();
    ev_rsf = 1; step();
    wr(3'd3, 8'h38);
    rd(3'd2, 8'h29, "R9 flags");
    check("R9 released hi", {7'd0, irq_line}, 8'h00);
    wr(3'd3, 8'h39);
    ev_pd = 1; bus_addr = 3'd2; bus_rd = 1; step();
    check("R9 rise with read keeps line", {7'd0, irq_line}, 8'h01);

    // R12
    wr(3'd4, 8'hFF);
    wr(3'd2, 8'hFF);
    rd(3'd3, 8'h39, "R12 enable untouched");
    rd(3'd2, 8'h09, "R12 flags untouched");
    rd(3'd5, 8'h00, "R12 other offset reads zero");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule